// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between time slots on a frame-synchronous serial bus. Eight bit-serial input lanes, arranged as two groups of four, each carry 32 eight-bit channels per frame. Every incoming byte is shifted in MSB first and stored in a two-bank data memory, with one bank filling while the other holds the frame before. Each output lane and channel has an entry in a connection memory. That entry names the input lane and channel to replay in the slot, or replaces the switched byte with a fixed byte, all ones, or an undriven lane.

A one-cycle frame pulse marks the first bit of channel 0 and restarts the slot counters. Software reaches both memories through a small register port. Connection entries can be written and read, and they are cleared at reset or by a one-cycle initialise input. Stored input bytes can only be read.

Top module: `tsi_switch`

## Requirements
- R1: A high `frame_pulse` marks the cycle that carries the MSB of channel 0. Each channel then takes 8 cycles, MSB first, and a frame takes 32 channels, or 256 cycles.
- R2: With control bits 11..8 of a connection entry all clear, the output slot carries the byte that arrived in the source slot during the previous frame. Bits 7..5 of the entry name the source lane (group times four plus the lane within the group) and bits 4..0 name the source channel.
- R3: With only bit 8 (low-latency) set among the control bits, the slot carries the current frame's byte when the source channel number is lower than the output channel number, and the previous frame's byte otherwise.
- R4: Bit 11 (off) holds `ser_oe` low and `ser_out` low for all 8 bits of the slot, whatever the other bits are.
- R5: Bit 10 (ones), when bit 11 is clear, drives 8'hFF regardless of bits 9 and 8.
- R6: Bit 9 (message), when bits 11 and 10 are clear, drives entry bits 7..0 as the byte, whatever bit 8 is.
- R7: A write with `cfg_addr[8]`=0 stores `cfg_wdata` in the entry of output lane `cfg_addr[7:5]` and channel `cfg_addr[4:0]`. A read strobe returns that entry on `cfg_rdata` one clock later.
- R8: After reset every connection entry reads as zero, so every lane is driven.
- R9: A cycle with `blk_init` high clears every connection entry, even when a write happens in the same cycle.
- R10: A read with `cfg_addr[8]`=1 returns, zero-extended, the byte that input lane `cfg_addr[7:5]` carried in channel `cfg_addr[4:0]` of the previous frame. A write to that range changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Marks the first bit of a frame |
| ser_in | input | 8 | Serial input lanes |
| ser_out | output | 8 | Serial output lanes |
| ser_oe | output | 8 | Per-lane drive enable |
| cfg_addr | input | 9 | Bit 8 selects stored data, bits 7..5 lane, bits 4..0 channel |
| cfg_wdata | input | 12 | Connection entry to write |
| cfg_we | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| blk_init | input | 1 | Clears the connection memory |
| cfg_rdata | output | 12 | Read result, one clock after the strobe |

## Verification
Every input lane gets a byte that changes with frame, lane and channel, so a wrong source lane, a wrong channel or a stale frame each gives a different value. Low-latency entries are set with a source channel below, equal to, and above the output channel, including the channel 31 to channel 0 and channel 30 to channel 31 edges, which separates current-frame from previous-frame replay. Entries with several control bits set check the precedence order. Reads of stored data taken after the last frame pulse show which bank the register port sees.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic [1:0] {
    SEL_SWITCH = 2'd0,
    SEL_MSG    = 2'd1,
    SEL_ONES   = 2'd2,
    SEL_OFF    = 2'd3
  } slot_sel_e;

  // Precedence of the per-slot controls: off, then ones, then message.
  function automatic slot_sel_e slot_select(input logic off, input logic ones, input logic msg);
    if (off)  return SEL_OFF;
    if (ones) return SEL_ONES;
    if (msg)  return SEL_MSG;
    return SEL_SWITCH;
  endfunction

  // A low-latency slot may use this frame's byte only once the source slot is complete.
  function automatic logic take_current(input logic low_lat, input int unsigned src_ch,
                                        input int unsigned out_ch);
    return low_lat && (src_ch < out_ch);
  endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int CHANNELS = 32,
  parameter int BITS     = 8,
  localparam int CW = $clog2(CHANNELS),
  localparam int BW = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  output logic [CW-1:0] cur_ch,
  output logic [BW-1:0] cur_bit,
  output logic          byte_done,
  output logic          wr_bank
);
  localparam int PW    = CW + BW;
  localparam int TOTAL = CHANNELS * BITS;

  logic [PW-1:0] pos_q, cur_pos;
  logic          bank_q;

  always_comb begin
    if (frame_pulse)                  cur_pos = '0;
    else if (pos_q == PW'(TOTAL - 1)) cur_pos = '0;
    else                              cur_pos = pos_q + 1'b1;
  end

  assign cur_ch    = cur_pos[PW-1:BW];
  assign cur_bit   = cur_pos[BW-1:0];
  assign byte_done = (cur_bit == BW'(BITS - 1));
  assign wr_bank   = frame_pulse ? ~bank_q : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      pos_q  <= cur_pos;
      bank_q <= wr_bank;
    end
  end

  // R1: bits advance by one each clock unless a frame pulse restarts them
  a_r1_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_pulse || cur_bit == BW'($past(cur_bit) + 1'b1)));
  // R1: the channel holds for the whole slot
  a_r1_channel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_pulse || $past(byte_done) || cur_ch == $past(cur_ch)));
  // R2: the fill bank only changes at a frame boundary
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_pulse || wr_bank == $past(wr_bank)));

endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
  parameter int NS       = 8,
  parameter int CHANNELS = 32,
  parameter int BITS     = 8,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(CHANNELS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NS-1:0]            ser_in,
  input  logic [CW-1:0]            cur_ch,
  input  logic                     byte_done,
  input  logic                     wr_bank,
  input  logic [NS-1:0][SW-1:0]    rd_stream,
  input  logic [NS-1:0][CW-1:0]    rd_chan,
  input  logic [NS-1:0]            rd_bank,
  output logic [NS-1:0][BITS-1:0]  rd_byte,
  input  logic [SW-1:0]            cpu_stream,
  input  logic [CW-1:0]            cpu_chan,
  output logic [BITS-1:0]          cpu_byte
);
  logic [BITS-1:0]          shift_q [NS];
  logic [NS-1:0][BITS-1:0]  rx_byte;
  logic [BITS-1:0]          dmem_q  [2][NS][CHANNELS];

  for (genvar s = 0; s < NS; s++) begin : g_lane
    assign rx_byte[s] = {shift_q[s][BITS-2:0], ser_in[s]};
    assign rd_byte[s] = dmem_q[rd_bank[s]][rd_stream[s]][rd_chan[s]];
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      shift_q[s] <= rx_byte[s];
      if (byte_done) dmem_q[wr_bank][s][cur_ch] <= rx_byte[s];
    end
  end

  // The register port sees the bank holding the previous frame.
  assign cpu_byte = dmem_q[~wr_bank][cpu_stream][cpu_chan];

  // R2: a completed byte lands in the bank that was filling
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> dmem_q[$past(wr_bank)][0][$past(cur_ch)] == $past(rx_byte[0]));

endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int NS       = 8,
  parameter int CHANNELS = 32,
  parameter int BITS     = 8,
  parameter int EW       = 12,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(CHANNELS),
  localparam int AW = 1 + SW + CW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  blk_init,
  input  logic                  cfg_we,
  input  logic                  cfg_rd,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [EW-1:0]         cfg_wdata,
  output logic [EW-1:0]         cfg_rdata,
  input  logic [CW-1:0]         cur_ch,
  output logic [NS-1:0][EW-1:0] slot_entry,
  output logic [SW-1:0]         cpu_stream,
  output logic [CW-1:0]         cpu_chan,
  input  logic [BITS-1:0]       cpu_byte
);
  logic [EW-1:0] cm_q [NS][CHANNELS];
  logic [EW-1:0] rdata_q;
  logic          to_data, cm_write;

  assign to_data    = cfg_addr[AW-1];
  assign cpu_stream = cfg_addr[SW+CW-1:CW];
  assign cpu_chan   = cfg_addr[CW-1:0];
  assign cm_write   = cfg_we && !to_data;
  assign cfg_rdata  = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++)
        for (int c = 0; c < CHANNELS; c++) cm_q[s][c] <= '0;
      rdata_q <= '0;
    end else begin
      if (blk_init) begin
        for (int s = 0; s < NS; s++)
          for (int c = 0; c < CHANNELS; c++) cm_q[s][c] <= '0;
      end else if (cm_write) begin
        cm_q[cpu_stream][cpu_chan] <= cfg_wdata;
      end
      if (cfg_rd) rdata_q <= to_data ? EW'(cpu_byte) : cm_q[cpu_stream][cpu_chan];
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_slot
    assign slot_entry[s] = cm_q[s][cur_ch];
  end

  // R7: a write lands in the addressed entry
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cm_write && !blk_init |=> cm_q[$past(cpu_stream)][$past(cpu_chan)] == $past(cfg_wdata));
  // R9: initialise beats a simultaneous write
  a_r9_init_wins: assert property (@(posedge clk) disable iff (!rst_n)
    blk_init |=> cm_q[$past(cpu_stream)][$past(cpu_chan)] == '0);
  // R10: writes aimed at stored data leave the connection entry alone
  a_r10_data_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && to_data && !blk_init |=>
      cm_q[$past(cpu_stream)][$past(cpu_chan)] == $past(cm_q[cpu_stream][cpu_chan]));

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
  import tsi_pkg::*;
#(
  parameter int NS       = 8,
  parameter int CHANNELS = 32,
  parameter int BITS     = 8,
  parameter int EW       = 12,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(CHANNELS),
  localparam int BW = $clog2(BITS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NS-1:0][EW-1:0]    slot_entry,
  input  logic [CW-1:0]            cur_ch,
  input  logic [BW-1:0]            cur_bit,
  input  logic                     wr_bank,
  output logic [NS-1:0][SW-1:0]    rd_stream,
  output logic [NS-1:0][CW-1:0]    rd_chan,
  output logic [NS-1:0]            rd_bank,
  input  logic [NS-1:0][BITS-1:0]  rd_byte,
  output logic [NS-1:0]            ser_out,
  output logic [NS-1:0]            ser_oe
);
  localparam int B_OFF  = EW - 1;
  localparam int B_ONES = EW - 2;
  localparam int B_MSG  = EW - 3;
  localparam int B_LOW  = EW - 4;

  for (genvar s = 0; s < NS; s++) begin : g_lane
    slot_sel_e       sel;
    logic [BITS-1:0] out_byte;
    logic            use_now;

    assign rd_stream[s] = slot_entry[s][SW+CW-1:CW];
    assign rd_chan[s]   = slot_entry[s][CW-1:0];
    assign use_now      = take_current(slot_entry[s][B_LOW], 32'(rd_chan[s]), 32'(cur_ch));
    assign rd_bank[s]   = use_now ? wr_bank : ~wr_bank;
    assign sel          = slot_select(slot_entry[s][B_OFF], slot_entry[s][B_ONES],
                                      slot_entry[s][B_MSG]);

    always_comb begin
      case (sel)
        SEL_SWITCH: out_byte = rd_byte[s];
        SEL_MSG:    out_byte = slot_entry[s][BITS-1:0];
        SEL_ONES:   out_byte = '1;
        default:    out_byte = '0;
      endcase
    end

    assign ser_out[s] = out_byte[BW'(BITS - 1) - cur_bit];
    assign ser_oe[s]  = (sel != SEL_OFF);

    // R4: an off slot is undriven and low
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      slot_entry[s][B_OFF] |-> (!ser_oe[s] && !ser_out[s]));
    // R5: ones wins over message and switched data
    a_r5_ones_high: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_entry[s][B_OFF] && slot_entry[s][B_ONES] |-> (ser_oe[s] && ser_out[s]));
    // R3: an incomplete source slot is taken from the held bank
    a_r3_not_ready_prev: assert property (@(posedge clk) disable iff (!rst_n)
      slot_entry[s][B_LOW] && rd_chan[s] >= cur_ch |-> rd_bank[s] != wr_bank);
  end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int GROUPS    = 2,
  parameter int PER_GROUP = 4,
  parameter int CHANNELS  = 32,
  parameter int BITS      = 8,
  localparam int NS    = GROUPS * PER_GROUP,
  localparam int SW    = $clog2(NS),
  localparam int CW    = $clog2(CHANNELS),
  localparam int BW    = $clog2(BITS),
  localparam int LOW_W = (SW + CW > BITS) ? SW + CW : BITS,
  localparam int EW    = LOW_W + 4,
  localparam int AW    = 1 + SW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  input  logic [NS-1:0] ser_in,
  output logic [NS-1:0] ser_out,
  output logic [NS-1:0] ser_oe,
  input  logic [AW-1:0] cfg_addr,
  input  logic [EW-1:0] cfg_wdata,
  input  logic          cfg_we,
  input  logic          cfg_rd,
  input  logic          blk_init,
  output logic [EW-1:0] cfg_rdata
);
  logic [CW-1:0]            cur_ch;
  logic [BW-1:0]            cur_bit;
  logic                     byte_done, wr_bank;
  logic [NS-1:0][EW-1:0]    slot_entry;
  logic [NS-1:0][SW-1:0]    rd_stream;
  logic [NS-1:0][CW-1:0]    rd_chan;
  logic [NS-1:0]            rd_bank;
  logic [NS-1:0][BITS-1:0]  rd_byte;
  logic [SW-1:0]            cpu_stream;
  logic [CW-1:0]            cpu_chan;
  logic [BITS-1:0]          cpu_byte;

  tsi_timing #(.CHANNELS(CHANNELS), .BITS(BITS)) u_timing (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .cur_ch(cur_ch), .cur_bit(cur_bit), .byte_done(byte_done), .wr_bank(wr_bank));

  tsi_rx #(.NS(NS), .CHANNELS(CHANNELS), .BITS(BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .cur_ch(cur_ch), .byte_done(byte_done),
    .wr_bank(wr_bank), .rd_stream(rd_stream), .rd_chan(rd_chan), .rd_bank(rd_bank),
    .rd_byte(rd_byte), .cpu_stream(cpu_stream), .cpu_chan(cpu_chan), .cpu_byte(cpu_byte));

  tsi_cmem #(.NS(NS), .CHANNELS(CHANNELS), .BITS(BITS), .EW(EW)) u_cmem (
    .clk(clk), .rst_n(rst_n), .blk_init(blk_init), .cfg_we(cfg_we), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cur_ch(cur_ch),
    .slot_entry(slot_entry), .cpu_stream(cpu_stream), .cpu_chan(cpu_chan),
    .cpu_byte(cpu_byte));

  tsi_tx #(.NS(NS), .CHANNELS(CHANNELS), .BITS(BITS), .EW(EW)) u_tx (
    .clk(clk), .rst_n(rst_n), .slot_entry(slot_entry), .cur_ch(cur_ch), .cur_bit(cur_bit),
    .wr_bank(wr_bank), .rd_stream(rd_stream), .rd_chan(rd_chan), .rd_bank(rd_bank),
    .rd_byte(rd_byte), .ser_out(ser_out), .ser_oe(ser_oe));

endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
  localparam int NS = 8, CH = 32, AW = 9, EW = 12, NV = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, frame_pulse, cfg_we, cfg_rd, blk_init;
  logic [NS-1:0] ser_in, ser_out, ser_oe;
  logic [AW-1:0] cfg_addr;
  logic [EW-1:0] cfg_wdata, cfg_rdata;

  tsi_switch uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rd(cfg_rd), .blk_init(blk_init), .cfg_rdata(cfg_rdata));

  int checks = 0, errors = 0;
  bit done = 0;

  // {out lane, out channel, off, ones, msg, low-latency, low byte}
  localparam logic [19:0] VEC [NV] = '{
    {3'd1, 5'd5,  4'b0000, 3'd2, 5'd9},
    {3'd2, 5'd10, 4'b0001, 3'd3, 5'd4},
    {3'd3, 5'd4,  4'b0001, 3'd0, 5'd4},
    {3'd4, 5'd0,  4'b0001, 3'd7, 5'd31},
    {3'd5, 5'd31, 4'b0001, 3'd6, 5'd30},
    {3'd6, 5'd7,  4'b0010, 8'hA5},
    {3'd7, 5'd8,  4'b0100, 8'h3C},
    {3'd0, 5'd9,  4'b1000, 8'h00},
    {3'd1, 5'd12, 4'b1110, 8'h77},
    {3'd2, 5'd13, 4'b0110, 8'h00},
    {3'd3, 5'd14, 4'b0011, 8'h5A},
    {3'd4, 5'd20, 4'b0000, 3'd7, 5'd31}
  };

  logic [EW-1:0] model [NS][CH];

  function automatic logic [7:0] in_byte(int k, int s, int c);
    return 8'(((k * 67) + (s * 29) + (c * 13) + 7) ^ (c << 3));
  endfunction

  // Expected {enable byte, data byte} of a slot, restated from R2..R6.
  function automatic logic [15:0] expect_slot(int k, int c, logic [EW-1:0] e);
    int fr;
    if (e[11]) return 16'h0000;
    if (e[10]) return 16'hFFFF;
    if (e[9])  return {8'hFF, e[7:0]};
    fr = (e[8] && (int'(e[4:0]) < c)) ? k : k - 1;
    return {8'hFF, in_byte(fr, int'(e[7:5]), int'(e[4:0]))};
  endfunction

  function automatic string tag_of(logic [EW-1:0] e);
    if (e[11]) return "R1/R4";
    if (e[10]) return "R1/R5";
    if (e[9])  return "R1/R6";
    if (e[8])  return "R1/R3";
    return "R1/R2";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [AW-1:0] a, logic [EW-1:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cpu_read(logic [AW-1:0] a, output logic [EW-1:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    #1 d = cfg_rdata;
  endtask

  initial begin
    logic [EW-1:0] d;
    logic [7:0]    dat_acc [NS];
    logic [7:0]    oe_acc  [NS];
    rst_n = 1'b0; frame_pulse = 1'b0; ser_in = '0; cfg_we = 1'b0; cfg_rd = 1'b0;
    blk_init = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int s = 0; s < NS; s++) for (int c = 0; c < CH; c++) model[s][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    @(negedge clk); #1;
    chk("R8 lanes driven after reset", 32'(ser_oe), 32'hFF);
    cpu_read(9'h000, d);
    chk("R8 entry zero after reset", 32'(d), 32'h0);

    // R7: program the table and read it back
    for (int i = 0; i < NV; i++) begin
      cpu_write({1'b0, VEC[i][19:12]}, VEC[i][11:0]);
      model[VEC[i][19:17]][VEC[i][16:12]] = VEC[i][11:0];
    end
    for (int i = 0; i < NV; i++) begin
      cpu_read({1'b0, VEC[i][19:12]}, d);
      chk("R7 entry readback", 32'(d), 32'(VEC[i][11:0]));
    end

    // R1..R6: four frames of traffic, every slot compared from frame 1 on
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < CH; c++) begin
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          frame_pulse = (c == 0 && b == 0);
          for (int s = 0; s < NS; s++) begin
            logic [7:0] v;
            v = in_byte(k, s, c);
            ser_in[s] = v[7-b];
          end
          #1;
          for (int s = 0; s < NS; s++) begin
            dat_acc[s] = {dat_acc[s][6:0], ser_out[s]};
            oe_acc[s]  = {oe_acc[s][6:0], ser_oe[s]};
          end
          if (b == 7 && k >= 1) begin
            for (int s = 0; s < NS; s++)
              chk($sformatf("%s lane %0d ch %0d frame %0d", tag_of(model[s][c]), s, c, k),
                  32'({oe_acc[s], dat_acc[s]}), 32'(expect_slot(k, c, model[s][c])));
          end
        end
      end
    end
    @(negedge clk);
    frame_pulse = 1'b0; ser_in = '0;

    // R10: stored data reads return the frame before the current one (frame 2)
    cpu_read({1'b1, 3'd2, 5'd9}, d);
    chk("R10 stored byte lane 2 ch 9", 32'(d), 32'(in_byte(2, 2, 9)));
    cpu_read({1'b1, 3'd7, 5'd31}, d);
    chk("R10 stored byte lane 7 ch 31", 32'(d), 32'(in_byte(2, 7, 31)));
    cpu_write({1'b1, 3'd1, 5'd5}, 12'h0FF);
    cpu_read({1'b0, 3'd1, 5'd5}, d);
    chk("R10 data write leaves entry", 32'(d), 32'(VEC[0][11:0]));
    cpu_read({1'b1, 3'd1, 5'd5}, d);
    chk("R10 data write leaves byte", 32'(d), 32'(in_byte(2, 1, 5)));

    // R9: initialise clears everything and beats a same-cycle write
    @(negedge clk);
    cfg_addr = {1'b0, 3'd6, 5'd7}; cfg_wdata = 12'h2AB; cfg_we = 1'b1; blk_init = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; blk_init = 1'b0;
    cpu_read({1'b0, 3'd6, 5'd7}, d);
    chk("R9 init beats write", 32'(d), 32'h0);
    cpu_read({1'b0, 3'd1, 5'd5}, d);
    chk("R9 init clears entry", 32'(d), 32'h0);

    // R8: reset clears a programmed entry
    cpu_write({1'b0, 3'd3, 5'd3}, 12'h123);
    cpu_read({1'b0, 3'd3, 5'd3}, d);
    chk("R7 write before reset", 32'(d), 32'h123);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cpu_read({1'b0, 3'd3, 5'd3}, d);
    chk("R8 reset clears entry", 32'(d), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule